// File: doc/BRIEF.md
# Transactional Store-Gathering Buffer

This block sits between a first-level data cache and the next cache level and collects stores into line-sized entries before they are written back. Every entry carries a line address, one line of data, a mask of the bytes that hold store data, and a second per-byte mask that marks which of those bytes were written speculatively inside a transaction. An incoming store whose line address matches an open entry is folded into that entry. Otherwise it claims the entry at the tail of a circular queue. Entries leave from the head of the queue, oldest first, over a ready/valid write-back port.

Transaction control arrives as two single-cycle strobes. A commit turns every speculative byte into an ordinary one. An abort discards every speculative byte and keeps the bytes that came from non-speculative stores, so those stores still reach the next level. An entry left with no bytes is dropped from the write-back sequence. Speculative data never leaves the block: an entry at the head that still holds speculative bytes waits for the outcome of the transaction. Coherence traffic and the next-level memory are outside this block.

Top module: `tgsb_buffer`

## Requirements
- R1: After reset, `st_ready` is 1 and `wb_valid` is 0.
- R2: A store whose line matches no open non-head entry takes a new entry. Entries appear on the write-back port in allocation order, oldest first, with their line, data and byte mask (bit b of a byte mask covers data bits 8b+7..8b).
- R3: A store whose line matches an open entry other than the head merges into it. Bytes selected by its mask overwrite the old bytes, other bytes keep their values, the byte mask becomes the union, and no entry is added.
- R4: The head entry takes no merges. A store to the head's line takes a new entry, and the head drains with its earlier contents.
- R5: When every entry is occupied, `st_ready` is 0. It returns to 1 in the cycle after a write-back handshake.
- R6: While `wb_valid` is 1 and `wb_ready` is 0, and no abort is strobed, `wb_valid`, `wb_line` and `wb_bmask` hold their values.
- R7: An abort removes every transactional byte from the byte masks. Non-transactional bytes of the same entries still drain with their data.
- R8: An entry whose bytes were all transactional is never offered on the write-back port after an abort, and the next entry in age order follows it.
- R9: A commit makes every transactional byte ordinary, so a later abort leaves those bytes in place.
- R10: A non-transactional store over a transactional byte makes that byte non-transactional. A transactional store over an ordinary byte makes it transactional.
- R11: `st_ready` is 0 in any cycle in which the commit or abort strobe is high.
- R12: A head entry that holds any transactional byte is not offered for write-back until a commit or abort resolves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_line | input | LINE_AW | Line address of the store |
| st_data | input | LINE_BYTES*8 | Store data aligned to the line |
| st_bmask | input | LINE_BYTES | Bytes written by the store |
| st_tx | input | 1 | Store belongs to the open transaction |
| tx_commit | input | 1 | Transaction commit strobe |
| tx_abort | input | 1 | Transaction abort strobe |
| wb_valid | output | 1 | Head entry offered for write-back |
| wb_ready | input | 1 | Next level takes the head entry |
| wb_line | output | LINE_AW | Line address of the head entry |
| wb_data | output | LINE_BYTES*8 | Data of the head entry |
| wb_bmask | output | LINE_BYTES | Valid bytes of the head entry |

## Verification
The hardest case to reach from the ports is an abort that meets a queue holding both a mixed entry and a wholly transactional entry behind an ordinary head. This must happen while the drain side is held off, so that the emptied entry has to be skipped later without a handshake. The stimulus places a non-transactional filler store at the head first, so that the later stores are open to merging. It then builds the mixed and the speculative entries behind it, strobes the abort, and only then drains. The checks on line order and masked data expose a skipped or leaked entry. Byte ownership flipping in both directions on a merge is driven the same way.

// File: rtl/tgsb_pkg.sv
package tgsb_pkg;
  // queue operation requested in one cycle: {push, pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } ring_op_e;
endpackage

// File: rtl/tgsb_ring.sv
module tgsb_ring
  import tgsb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [CNT_W-1:0] count;
  ring_op_e         op;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + IDX_W'(1);
  endfunction

  assign op   = ring_op_e'({push, pop});
  assign full = (count == CNT_W'(NUM_ENT));

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          tail  <= step(tail);
          count <= count + CNT_W'(1);
        end
        OP_POP: begin
          head  <= step(head);
          count <= count - CNT_W'(1);
        end
        OP_BOTH: begin
          tail <= step(tail);
          head <= step(head);
        end
        default: ;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(NUM_ENT));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/tgsb_cam.sv
module tgsb_cam #(
  parameter int NUM_ENT = 64,
  parameter int LINE_AW = 32,
  parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT-1:0] occ,
  input  logic [LINE_AW-1:0] lines [NUM_ENT],
  input  logic [IDX_W-1:0]   head,
  input  logic [LINE_AW-1:0] key,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  // lowest matching index wins; the head is never a candidate
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (occ[i] && lines[i] == key && IDX_W'(i) != head) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tgsb_buffer.sv
module tgsb_buffer #(
  parameter int NUM_ENT    = 64,
  parameter int LINE_BYTES = 128,
  parameter int LINE_AW    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [LINE_AW-1:0]      st_line,
  input  logic [LINE_BYTES*8-1:0] st_data,
  input  logic [LINE_BYTES-1:0]   st_bmask,
  input  logic                    st_tx,
  input  logic                    tx_commit,
  input  logic                    tx_abort,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [LINE_AW-1:0]      wb_line,
  output logic [LINE_BYTES*8-1:0] wb_data,
  output logic [LINE_BYTES-1:0]   wb_bmask
);
  localparam int DATA_W = LINE_BYTES * 8;
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W  = $clog2(NUM_ENT + 1);

  logic [LINE_AW-1:0]    line_q [NUM_ENT];
  logic [DATA_W-1:0]     data_q [NUM_ENT];
  logic [LINE_BYTES-1:0] vmask_q[NUM_ENT];
  logic [LINE_BYTES-1:0] txm_q  [NUM_ENT];
  logic [NUM_ENT-1:0]    occ_q;

  logic [IDX_W-1:0] head, tail, hit_idx, wr_idx;
  logic             full, hit, st_fire, push, pop, head_void, any_tx;

  tgsb_ring #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .head(head), .tail(tail), .full(full)
  );

  tgsb_cam #(.NUM_ENT(NUM_ENT), .LINE_AW(LINE_AW), .IDX_W(IDX_W)) u_cam (
    .occ(occ_q), .lines(line_q), .head(head), .key(st_line),
    .hit(hit), .hit_idx(hit_idx)
  );

  // head side: an emptied entry is retired silently, a speculative one waits
  assign head_void = occ_q[head] && (vmask_q[head] == '0);
  assign wb_valid  = occ_q[head] && (vmask_q[head] != '0) && (txm_q[head] == '0);
  assign wb_line   = line_q[head];
  assign wb_data   = data_q[head];
  assign wb_bmask  = vmask_q[head];
  assign pop       = (wb_valid && wb_ready) || head_void;

  // store side
  assign st_ready = !full && !tx_abort && !tx_commit;
  assign st_fire  = st_valid && st_ready;
  assign push     = st_fire && !hit;
  assign wr_idx   = hit ? hit_idx : tail;

  always_comb begin
    any_tx = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) any_tx = any_tx | (|txm_q[i]);
  end

  // control state: occupancy, byte masks, line tags
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        vmask_q[i] <= '0;
        txm_q[i]   <= '0;
        line_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (tx_abort) begin
          vmask_q[i] <= vmask_q[i] & ~txm_q[i];
          txm_q[i]   <= '0;
        end else if (tx_commit) begin
          txm_q[i] <= '0;
        end
      end
      if (pop) occ_q[head] <= 1'b0;
      if (st_fire) begin
        if (hit) begin
          vmask_q[wr_idx] <= vmask_q[wr_idx] | st_bmask;
          txm_q[wr_idx]   <= st_tx ? (txm_q[wr_idx] | st_bmask)
                                   : (txm_q[wr_idx] & ~st_bmask);
        end else begin
          occ_q[wr_idx]   <= 1'b1;
          line_q[wr_idx]  <= st_line;
          vmask_q[wr_idx] <= st_bmask;
          txm_q[wr_idx]   <= st_tx ? st_bmask : '0;
        end
      end
    end
  end

  // data array: one byte-enabled write port, one read port at the head
  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (st_fire && st_bmask[b]) data_q[wr_idx][b*8 +: 8] <= st_data[b*8 +: 8];
    end
  end

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    full |-> !st_ready);

  assert_head_no_merge_R4: assert property (@(posedge clk) disable iff (rst)
    (st_fire && hit) |-> (hit_idx != head));

  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready && !tx_abort) |=>
      (wb_valid && $stable(wb_line) && $stable(wb_bmask)));

  assert_abort_purges_R7: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !any_tx);

  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (rst)
    tx_commit |=> !any_tx);

  assert_no_spec_drain_R12: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (txm_q[head] == '0));

  assert_strobe_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_abort || tx_commit) |-> !st_ready);
endmodule

// File: tb/test_tgsb_buffer.sv
module test_tgsb_buffer;
  localparam int PERIOD = 10;
  localparam int NE = 4;
  localparam int LB = 4;
  localparam int AW = 8;
  localparam int DW = LB * 8;
  localparam int VW = 2 + AW + DW + LB + 1;

  // vector kinds
  localparam logic [1:0] K_ST = 2'd0, K_DR = 2'd1, K_AB = 2'd2, K_CM = 2'd3;

  function automatic logic [VW-1:0] mk(input logic [1:0] k, input logic [AW-1:0] l,
                                       input logic [DW-1:0] d, input logic [LB-1:0] m,
                                       input logic t);
    return {k, l, d, m, t};
  endfunction

  localparam int NV = 24;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(K_ST, 8'h10, 32'h11223344, 4'hF, 1'b0),  // head
    mk(K_ST, 8'h20, 32'hAABBCCDD, 4'h3, 1'b0),
    mk(K_ST, 8'h20, 32'h55667788, 4'hC, 1'b0),  // R3 merge
    mk(K_ST, 8'h10, 32'h99999999, 4'h1, 1'b0),  // R4 head line
    mk(K_DR, 8'h10, 32'h11223344, 4'hF, 1'b0),  // R2
    mk(K_DR, 8'h20, 32'h5566CCDD, 4'hF, 1'b0),  // R3
    mk(K_DR, 8'h10, 32'h00000099, 4'h1, 1'b0),  // R4
    mk(K_ST, 8'h40, 32'h00000000, 4'hF, 1'b0),  // filler head
    mk(K_ST, 8'h30, 32'h01020304, 4'hF, 1'b1),
    mk(K_ST, 8'h30, 32'hA0A0A0A0, 4'h1, 1'b0),  // R10 non-tx over tx
    mk(K_ST, 8'h50, 32'h0000BEEF, 4'h3, 1'b1),  // all tx
    mk(K_AB, 8'h00, 32'h0, 4'h0, 1'b0),
    mk(K_DR, 8'h40, 32'h00000000, 4'hF, 1'b0),
    mk(K_DR, 8'h30, 32'h000000A0, 4'h1, 1'b0),  // R7 R10
    mk(K_ST, 8'h60, 32'hCAFEF00D, 4'hF, 1'b1),
    mk(K_CM, 8'h00, 32'h0, 4'h0, 1'b0),
    mk(K_AB, 8'h00, 32'h0, 4'h0, 1'b0),
    mk(K_DR, 8'h60, 32'hCAFEF00D, 4'hF, 1'b0),  // R8 skip, R9
    mk(K_ST, 8'h70, 32'h00000000, 4'hF, 1'b0),  // filler head
    mk(K_ST, 8'h80, 32'h11111111, 4'hF, 1'b0),
    mk(K_ST, 8'h80, 32'h22222222, 4'h2, 1'b1),  // R10 tx over ordinary
    mk(K_AB, 8'h00, 32'h0, 4'h0, 1'b0),
    mk(K_DR, 8'h70, 32'h00000000, 4'hF, 1'b0),
    mk(K_DR, 8'h80, 32'h11111111, 4'hD, 1'b0)   // R10
  };

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 1'b0, st_ready, st_tx = 1'b0, tx_commit = 1'b0, tx_abort = 1'b0;
  logic [AW-1:0] st_line = '0, wb_line;
  logic [DW-1:0] st_data = '0, wb_data;
  logic [LB-1:0] st_bmask = '0, wb_bmask;
  logic wb_valid, wb_ready = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tgsb_buffer #(.NUM_ENT(NE), .LINE_BYTES(LB), .LINE_AW(AW)) i_tgsb_buffer (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_line(st_line), .st_data(st_data), .st_bmask(st_bmask), .st_tx(st_tx),
    .tx_commit(tx_commit), .tx_abort(tx_abort), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_line(wb_line), .wb_data(wb_data), .wb_bmask(wb_bmask)
  );

  function automatic logic [DW-1:0] bits_of(input logic [LB-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < LB; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] l, input logic [DW-1:0] d,
                          input logic [LB-1:0] m, input logic t);
    st_valid = 1'b1; st_line = l; st_data = d; st_bmask = m; st_tx = t;
    #1;
    while (!st_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic strobe(input bit is_abort);
    if (is_abort) tx_abort = 1'b1; else tx_commit = 1'b1;
    #1;
    chk(!st_ready, "R11 st_ready during strobe", st_ready, 0);
    @(posedge clk); #1;
    tx_abort = 1'b0; tx_commit = 1'b0;
  endtask

  task automatic drain_check(input string req, input logic [AW-1:0] l,
                             input logic [DW-1:0] d, input logic [LB-1:0] m);
    for (int w = 0; w < 8 && !wb_valid; w++) begin @(posedge clk); #1; end
    chk(wb_valid == 1'b1, {req, " wb_valid"}, wb_valid, 1);
    chk(wb_line == l, {req, " wb_line"}, wb_line, l);
    chk(wb_bmask == m, {req, " wb_bmask"}, wb_bmask, m);
    chk((wb_data & bits_of(m)) == (d & bits_of(m)), {req, " wb_data"},
        wb_data & bits_of(m), d & bits_of(m));
    wb_ready = 1'b1;
    @(posedge clk); #1;
    wb_ready = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk(st_ready == 1'b1, "R1 st_ready after reset", st_ready, 1);
    chk(wb_valid == 1'b0, "R1 wb_valid after reset", wb_valid, 0);

    // table walk: gathering, ordering, abort and commit cases
    for (int v = 0; v < NV; v++) begin
      logic [1:0] k; logic [AW-1:0] l; logic [DW-1:0] d; logic [LB-1:0] m; logic t;
      {k, l, d, m, t} = VEC[v];
      case (k)
        K_ST: do_store(l, d, m, t);
        K_DR: drain_check($sformatf("R2/R3/R4/R7/R8/R9/R10 vec%0d", v), l, d, m);
        K_AB: strobe(1'b1);
        default: strobe(1'b0);
      endcase
    end
    repeat (3) @(posedge clk); #1;
    chk(wb_valid == 1'b0, "R8 nothing left after table", wb_valid, 0);

    // R12: speculative head waits for commit
    do_store(8'h90, 32'hDEADBEEF, 4'hF, 1'b1);
    repeat (3) @(posedge clk); #1;
    chk(wb_valid == 1'b0, "R12 tx head held", wb_valid, 0);
    strobe(1'b0);
    drain_check("R12 after commit", 8'h90, 32'hDEADBEEF, 4'hF);

    // R5 / R6: fill the buffer with the drain side stalled
    for (int n = 0; n < NE; n++) do_store(AW'(8'hA0 + n), DW'(n), 4'hF, 1'b0);
    chk(st_ready == 1'b0, "R5 full blocks stores", st_ready, 0);
    repeat (2) @(posedge clk); #1;
    chk(wb_valid == 1'b1 && wb_line == 8'hA0, "R6 head held under stall",
        wb_line, 8'hA0);
    wb_ready = 1'b1;
    @(posedge clk); #1;
    wb_ready = 1'b0;
    chk(st_ready == 1'b1, "R5 ready after drain", st_ready, 1);
    for (int n = 1; n < NE; n++)
      drain_check("R2 fill order", AW'(8'hA0 + n), DW'(n), 4'hF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule